// File: doc/BRIEF.md
# Eight-Channel ADC Conversion Sequencer

This block is the digital controller that sits in front of a single 10-bit analog-to-digital converter shared by eight multiplexed inputs. Software programs a conversion length and a channel, then starts either a one-off conversion of that channel or a sweep that walks upward from that channel to the highest one. The block drives the channel-select lines and marks the start and the sampling instant of every conversion. It captures each 10-bit code into a result register owned by that channel.

Completion of the whole job raises a sticky done flag, which is also the interrupt request. Software clears it explicitly. Issuing a new start while a job is running abandons the job in flight and begins the new one at once. The analog converter is modelled outside the block. It is told which channel to sample through `conv_chan` and `conv_start`, and it must have a valid code on `conv_code` by the cycle in which `conv_sample` is high.

Top module: `adcseq_top`

## Requirements
- R1: After reset every readable register reads 0, and `conv_start`, `conv_sample` and `irq` are low.
- R2: A write to address 0 with bit 0 set raises `conv_start` for exactly the following cycle, with `conv_chan` equal to the channel in bits 4:2 of the written word.
- R3: With the time register (address 1, bits 7:0) holding T, each conversion lasts T+1 cycles. `conv_sample` is high in the last of them only, and the code is captured at the clock edge that ends it. A single conversion therefore sets `irq` T+1 edges after the start write.
- R4: Single mode (bit 1 of the start word is 0) converts only the chosen channel. Every other result register keeps its value.
- R5: Scan mode (bit 1 set) converts the chosen channel and then each higher channel in ascending order up to channel 7, with no idle cycle between conversions. It then stops. A scan that starts at channel 7 converts that channel alone.
- R6: The result for channel n reads at address 8+n in bits 9:0. It changes only at the capture edge of a conversion of channel n, and it holds any code from 000h to 3FFh exactly.
- R7: The done flag (address 2, bit 0) and `irq` rise at the capture edge that ends a job. They stay high until a write to address 2 with bit 0 set. If that clear coincides with a completing capture, the flag stays set.
- R8: A start write during a running job discards the conversion in flight, leaving its result register unchanged, and restarts with the newly written channel and mode.
- R9: A write to address 0 with bit 0 clear only updates the stored mode and channel fields. A running job continues unchanged.
- R10: Address 0 reads back busy in bit 0, the last written mode in bit 1 and the last written channel in bits 4:2. Address 1 reads back the time setting. Unmapped addresses read 0.
- R11: The time setting is loaded at the start of each conversion, so a change written during a scan takes effect from the next channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| conv_start | output | 1 | One-cycle pulse beginning a conversion |
| conv_sample | output | 1 | High in the final cycle of a conversion; code is taken at its end |
| conv_chan | output | 3 | Channel being converted |
| conv_code | input | 10 | Code presented by the converter |
| irq | output | 1 | Interrupt request, equal to the done flag |

## Verification
The start pulse is registered and appears in the cycle directly after the write edge. The capture of a conversion with setting T lands on the edge T+1 after its start, and the done flag and interrupt follow on that same edge. The reference model advances on the same edges from the same inputs and is compared with the outputs at the falling edge of every cycle. Every output is therefore checked in the cycle it is due, and never merely at the end of a job. The directed tests also count edges from the start write to the rise of the interrupt and compare the count with the requirement's arithmetic: T+1 for a single conversion, and (T+1) multiplied by the number of channels for a scan. One test puts a clear write on the same edge as a capture.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    // register addresses
    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_TIME = 1;
    localparam int unsigned ADR_STAT = 2;
    localparam int unsigned ADR_RES0 = 8;
    // control word bit positions
    localparam int unsigned CTL_GO     = 0;
    localparam int unsigned CTL_SCAN   = 1;
    localparam int unsigned CTL_CH_LSB = 2;
endpackage

// File: rtl/adcseq_cfg.sv
module adcseq_cfg
    import adcseq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int RES_W  = 10,
    parameter int TIME_W = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic                          busy,
    input  logic                          seq_end,
    input  logic [NCH-1:0][RES_W-1:0]     res_all,
    output logic                          go,
    output logic                          go_scan,
    output logic [CH_W-1:0]               go_chan,
    output logic [TIME_W-1:0]             cfg_time,
    output logic                          done,
    output logic [DATA_W-1:0]             bus_rdata
);

    typedef struct packed {
        logic              scan;
        logic [CH_W-1:0]   chan;
        logic [TIME_W-1:0] ctime;
        logic              done;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ctrl, wr_time, wr_stat;
    wire  unused_wdata = ^bus_wdata;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
    assign wr_time = bus_wr && (bus_addr == ADDR_W'(ADR_TIME));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));

    assign go      = wr_ctrl && bus_wdata[CTL_GO];
    assign go_scan = bus_wdata[CTL_SCAN];
    assign go_chan = bus_wdata[CTL_CH_LSB +: CH_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.scan = bus_wdata[CTL_SCAN];
            cfg_d.chan = bus_wdata[CTL_CH_LSB +: CH_W];
        end
        if (wr_time) begin
            cfg_d.ctime = bus_wdata[TIME_W-1:0];
        end
        if (seq_end) begin
            cfg_d.done = 1'b1;
        end else if (wr_stat && bus_wdata[0]) begin
            cfg_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_time = cfg_q.ctime;
    assign done     = cfg_q.done;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CTRL)) begin
            bus_rdata[CTL_GO]                = busy;
            bus_rdata[CTL_SCAN]              = cfg_q.scan;
            bus_rdata[CTL_CH_LSB +: CH_W]    = cfg_q.chan;
        end else if (bus_addr == ADDR_W'(ADR_TIME)) begin
            bus_rdata[TIME_W-1:0] = cfg_q.ctime;
        end else if (bus_addr == ADDR_W'(ADR_STAT)) begin
            bus_rdata[0] = cfg_q.done;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == ADDR_W'(ADR_RES0 + i)) begin
                    bus_rdata[RES_W-1:0] = res_all[i];
                end
            end
        end
    end

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm #(
    parameter int NCH    = 8,
    parameter int TIME_W = 8,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_scan,
    input  logic [CH_W-1:0]   go_chan,
    input  logic [TIME_W-1:0] cfg_time,
    output logic              busy,
    output logic              conv_start,
    output logic              conv_sample,
    output logic [CH_W-1:0]   conv_chan,
    output logic              cap_en,
    output logic              seq_end
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    typedef struct packed {
        logic              busy;
        logic              scan;
        logic [CH_W-1:0]   chan;
        logic [TIME_W-1:0] cnt;
        logic              start;
    } seq_t;

    seq_t seq_d, seq_q;
    logic at_end;
    logic last;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        at_end      = seq_q.busy && (seq_q.cnt == '0);
        last        = !seq_q.scan || (seq_q.chan == LAST_CH);
        if (go) begin
            seq_d.busy  = 1'b1;
            seq_d.scan  = go_scan;
            seq_d.chan  = go_chan;
            seq_d.cnt   = cfg_time;
            seq_d.start = 1'b1;
        end else if (at_end) begin
            if (last) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.chan  = seq_q.chan + 1'b1;
                seq_d.cnt   = cfg_time;
                seq_d.start = 1'b1;
            end
        end else if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy        = seq_q.busy;
    assign conv_start  = seq_q.start;
    assign conv_sample = at_end;
    assign conv_chan   = seq_q.chan;
    assign cap_en      = at_end && !go;
    assign seq_end     = cap_en && last;

endmodule

// File: rtl/adcseq_resbank.sv
module adcseq_resbank #(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en,
    input  logic [CH_W-1:0]           cap_chan,
    input  logic [RES_W-1:0]          cap_code,
    output logic [NCH-1:0][RES_W-1:0] res_all
);

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic [RES_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (cap_en && (cap_chan == CH_W'(g))) begin
                slot_d = cap_code;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign res_all[g] = slot_q;
    end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
    parameter int NCH    = 8,
    parameter int RES_W  = 10,
    parameter int TIME_W = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      conv_start,
    output logic                      conv_sample,
    output logic [$clog2(NCH)-1:0]    conv_chan,
    input  logic [RES_W-1:0]          conv_code,
    output logic                      irq
);

    localparam int CH_W = $clog2(NCH);

    logic                      go;
    logic                      go_scan;
    logic [CH_W-1:0]           go_chan;
    logic [TIME_W-1:0]         cfg_time;
    logic                      done;
    logic                      seq_busy;
    logic                      cap_en;
    logic                      seq_end;
    logic [NCH-1:0][RES_W-1:0] res_all;

    adcseq_cfg #(
        .NCH(NCH), .RES_W(RES_W), .TIME_W(TIME_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(seq_busy), .seq_end(seq_end), .res_all(res_all),
        .go(go), .go_scan(go_scan), .go_chan(go_chan),
        .cfg_time(cfg_time), .done(done), .bus_rdata(bus_rdata)
    );

    adcseq_fsm #(
        .NCH(NCH), .TIME_W(TIME_W), .CH_W(CH_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_scan(go_scan), .go_chan(go_chan), .cfg_time(cfg_time),
        .busy(seq_busy), .conv_start(conv_start), .conv_sample(conv_sample),
        .conv_chan(conv_chan), .cap_en(cap_en), .seq_end(seq_end)
    );

    adcseq_resbank #(
        .NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)
    ) u_res (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_chan(conv_chan), .cap_code(conv_code),
        .res_all(res_all)
    );

    assign irq = done;

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk
    import adcseq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int CH_W   = $clog2(NCH)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic                      conv_start,
    input logic                      conv_sample,
    input logic [CH_W-1:0]           conv_chan,
    input logic                      irq,
    input logic                      busy,
    input logic [NCH-1:0][RES_W-1:0] res_all
);

    logic go_w, clr_w;
    wire  unused_wdata = ^bus_wdata;

    assign go_w  = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL)) && bus_wdata[CTL_GO];
    assign clr_w = bus_wr && (bus_addr == ADDR_W'(ADR_STAT)) && bus_wdata[0];

    // R2: a start write is followed by a start pulse
    p_go_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go_w |=> conv_start);

    // R2: start pulses occur only inside a running job
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    // R3: the sampling cycle belongs to a running job
    p_sample_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_sample |-> busy);

    // R5: a start not caused by a write steps to the next channel
    p_chan_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !$past(go_w)) |-> (conv_chan == CH_W'($past(conv_chan) + CH_W'(1))));

    // R6: results move only after a sampling cycle
    p_res_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(conv_sample) |-> $stable(res_all));

    // R7: the request stays up until cleared
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_w) |=> irq);

    // R7: the request rises only after a sampling cycle
    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(conv_sample));

endmodule

bind adcseq_top adcseq_chk #(
    .NCH(NCH), .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .conv_start(conv_start), .conv_sample(conv_sample), .conv_chan(conv_chan),
    .irq(irq), .busy(seq_busy), .res_all(res_all)
);

// File: tb/adcseq_top_test.sv
module adcseq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [9:0]  conv_code = '0;
    wire  [15:0] bus_rdata;
    wire         conv_start;
    wire         conv_sample;
    wire  [2:0]  conv_chan;
    wire         irq;

    adcseq_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
        .conv_sample(conv_sample), .conv_chan(conv_chan), .conv_code(conv_code),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int go_cyc = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // ---------------- converter model ----------------
    int         n_conv = 0;
    int         order[$];
    logic [9:0] last_code [NCH];

    function automatic logic [9:0] pat(int ch, int k);
        case (k % 4)
            0:       return 10'h3FF;
            1:       return 10'h000;
            default: return 10'((ch * 97 + k * 41 + 3) % 1024);
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            conv_code = pat(int'(conv_chan), n_conv);
            last_code[conv_chan] = conv_code;
            order.push_back(int'(conv_chan));
            n_conv++;
        end
    end

    // ---------------- reference model ----------------
    bit         m_busy, m_scan, m_done, m_start;
    int         m_cur, m_left, m_time, m_chan;
    int         m_pend[$];
    logic [9:0] m_res [NCH];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_scan = 0; m_done = 0; m_start = 0;
            m_cur = 0; m_left = 0; m_time = 0; m_chan = 0;
            m_pend.delete();
            for (int i = 0; i < NCH; i++) m_res[i] = '0;
        end else begin
            bit go, clr, finish;
            int old_time;
            go       = bus_wr && bus_addr == 0 && bus_wdata[0];
            clr      = bus_wr && bus_addr == 2 && bus_wdata[0];
            old_time = m_time;
            finish   = 0;
            m_start  = 0;
            if (go) begin
                m_busy = 1;
                m_cur  = int'(bus_wdata[4:2]);
                m_pend.delete();
                if (bus_wdata[1])
                    for (int c = m_cur + 1; c < NCH; c++) m_pend.push_back(c);
                m_left  = old_time;
                m_start = 1;
            end else if (m_busy) begin
                if (m_left == 0) begin
                    m_res[m_cur] = conv_code;
                    if (m_pend.size() == 0) begin
                        m_busy = 0;
                        finish = 1;
                    end else begin
                        m_cur   = m_pend.pop_front();
                        m_left  = old_time;
                        m_start = 1;
                    end
                end else begin
                    m_left--;
                end
            end
            if (finish) m_done = 1;
            else if (clr) m_done = 0;
            if (bus_wr && bus_addr == 0) begin
                m_scan = bus_wdata[1];
                m_chan = int'(bus_wdata[4:2]);
            end
            if (bus_wr && bus_addr == 1) m_time = int'(bus_wdata[7:0]);
        end
    end

    function automatic logic [15:0] exp_read(logic [3:0] a);
        if (a == 0) return 16'(m_busy) | (16'(m_scan) << 1) | (16'(m_chan) << 2);
        if (a == 1) return 16'(m_time);
        if (a == 2) return 16'(m_done);
        if (a >= 8) return 16'(m_res[a - 8]);
        return 16'h0;
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 conv_start", 32'(conv_start), 32'(m_start));
            chk("R3 conv_sample", 32'(conv_sample), 32'(m_busy && m_left == 0));
            chk("R5 conv_chan", 32'(conv_chan), 32'(m_cur));
            chk("R7 irq", 32'(irq), 32'(m_done));
            chk("R10 readback", 32'(bus_rdata), 32'(exp_read(bus_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [15:0] ctl(bit g, bit s, int ch);
        return 16'(g) | (16'(s) << 1) | (16'(ch[2:0]) << 2);
    endfunction

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        if (a == 0 && d[0]) go_cyc = cyc;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        #1;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int n);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!irq && guard < 2000);
        if (!irq) chk("R7 watchdog waiting for irq", 0, 1);
        n = cyc - go_cyc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [9:0]  saved;
        int          n;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, v); chk("R1 ctrl after reset", v, 0);
        rd(1, v); chk("R1 time after reset", v, 0);
        rd(2, v); chk("R1 status after reset", v, 0);
        for (int i = 0; i < NCH; i++) begin
            rd(4'(8 + i), v); chk("R1 result after reset", v, 0);
        end
        chk("R1 conv_start idle", 32'(conv_start), 0);
        chk("R1 irq idle", 32'(irq), 0);

        // R3 / R4: single conversion of channel 5, T=3
        wr(1, 3);
        rd(1, v); chk("R10 time readback", v, 3);
        order.delete();
        wr(0, ctl(1, 0, 5));
        wait_irq(n);
        chk("R3 single latency", n, 4);
        rd(13, v); chk("R6 result ch5", v, 16'(last_code[5]));
        for (int i = 0; i < NCH; i++) begin
            if (i != 5) begin
                rd(4'(8 + i), v); chk("R4 other channel untouched", v, 0);
            end
        end
        chk("R4 one conversion", order.size(), 1);
        rd(0, v); chk("R10 ctrl readback", v, 16'(5 << 2));

        // R7: sticky flag then clear
        idle(10);
        chk("R7 irq sticky", 32'(irq), 1);
        wr(2, 1);
        chk("R7 irq cleared", 32'(irq), 0);
        rd(2, v); chk("R7 status cleared", v, 0);

        // R5: scan from channel 3, T=2
        wr(1, 2);
        order.delete();
        wr(0, ctl(1, 1, 3));
        wait_irq(n);
        chk("R5 scan latency", n, 15);
        chk("R5 scan count", order.size(), 5);
        for (int i = 0; i < 5 && i < order.size(); i++)
            chk("R5 scan order", order[i], 3 + i);
        for (int i = 3; i < NCH; i++) begin
            rd(4'(8 + i), v); chk("R6 scan result", v, 16'(last_code[i]));
        end
        for (int i = 0; i < 3; i++) begin
            rd(4'(8 + i), v); chk("R5 below start untouched", v, 0);
        end
        wr(2, 1);

        // R5: scan starting at the last channel
        order.delete();
        wr(0, ctl(1, 1, 7));
        wait_irq(n);
        chk("R5 last-channel scan latency", n, 3);
        chk("R5 last-channel scan count", order.size(), 1);
        wr(2, 1);

        // R3 / R6: T=0 full scan, codes include 000h and 3FFh
        wr(1, 0);
        order.delete();
        wr(0, ctl(1, 1, 0));
        wait_irq(n);
        chk("R3 zero-time scan latency", n, 8);
        chk("R5 full scan count", order.size(), 8);
        for (int i = 0; i < NCH; i++) begin
            rd(4'(8 + i), v); chk("R6 full range result", v, 16'(last_code[i]));
        end
        wr(2, 1);

        // R8: abort a running single conversion
        wr(1, 20);
        rd(10, v); saved = v[9:0];
        order.delete();
        wr(0, ctl(1, 0, 2));
        idle(5);
        wr(0, ctl(1, 0, 6));
        wait_irq(n);
        chk("R8 restart latency", n, 21);
        rd(10, v); chk("R8 aborted result kept", v, 16'(saved));
        rd(14, v); chk("R8 new result", v, 16'(last_code[6]));
        chk("R8 start count", order.size(), 2);
        wr(2, 1);

        // R9: config write without start during a scan
        wr(1, 4);
        order.delete();
        wr(0, ctl(1, 1, 0));
        idle(3);
        wr(0, ctl(0, 0, 1));
        wait_irq(n);
        chk("R9 scan unaffected latency", n, 40);
        chk("R9 scan unaffected count", order.size(), 8);
        rd(0, v); chk("R9 config updated", v, 16'(1 << 2));
        wr(2, 1);

        // R11: time change during a scan applies to the next channel
        wr(1, 2);
        wr(0, ctl(1, 1, 5));
        wr(1, 6);
        wait_irq(n);
        chk("R11 mixed time latency", n, 17);
        wr(2, 1);

        // R7: set wins over a simultaneous clear
        wr(1, 3);
        wr(0, ctl(1, 0, 1));
        idle(3);
        wr(2, 1);
        chk("R7 set beats clear", 32'(irq), 1);
        wr(2, 1);
        chk("R7 later clear", 32'(irq), 0);

        idle(2);
        report();
        $finish;
    end

endmodule